// File: doc/BRIEF.md
# Prefixed Bit-Test Execution Unit

This unit runs the two-byte bit-test instructions of an 8-bit CPU core. The main sequencer hands control over by pulsing a start strobe while the first opcode byte equals the prefix value 0xCB. The unit then reads the second opcode byte from the byte after the current program counter and holds it for the rest of the instruction. It splits that byte into a tested bit index and an operand selector. For a register operand it tests the bit straight away. For the memory operand it first reads the byte addressed by the HL pair and tests that byte one cycle later.

On completion the unit writes the flag register through a one-cycle write strobe and reports an instruction length of two bytes, so the sequencer can advance the program counter. A second byte outside the bit-test range is not executed. Instead the unit raises a one-cycle illegal-opcode pulse and returns to idle. The unit never writes a general register or memory.

Top module: `pfx_bit_unit`

## Requirements
- R1: A start is accepted only in a cycle where the unit is idle, `start` is high and `main_opcode` equals 0xCB. A start with any other opcode value has no effect: no memory read follows.
- R2: In the cycle after an accepted start, the unit drives `mem_rd` high with `mem_addr` equal to the sampled `pc` plus one, wrapping modulo 2^16 (0xFFFF gives 0x0000). Read data is taken from `mem_rdata` in the cycle after any request.
- R3: A second byte in 0x40..0x7F is a bit test. Bits [5:3] give the bit index. Bits [2:0] select the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A. On `gpr_flat`, B occupies bits [7:0], followed upward by C, D, E, H, L, with A in bits [55:48].
- R4: The written zero flag is 1 when the selected operand bit is 0, and 0 when that bit is 1.
- R5: The flag byte uses Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. A written flag byte has N cleared and H set, and copies bits [4:0] unchanged from `flags_in`.
- R6: For a register operand, `done` is high in the third cycle after the accepted start, and no memory read is issued in that cycle.
- R7: For the memory operand, the third cycle after the accepted start issues a read at `hl`. `done` follows in the fourth cycle, and the zero flag is taken from the returned byte.
- R8: `done` is a one-cycle pulse. It comes together with `flags_we` and with `instr_len` equal to 2. `flags_we` is never high without `done`.
- R9: A second byte outside 0x40..0x7F gives a one-cycle `illegal` pulse in the third cycle after the start, with no `done`, no flag write and no memory read. The unit is then idle again.
- R10: A start that arrives while an instruction is in progress is ignored. It causes no extra fetch and no extra completion.
- R11: While `rst_n` is low, and afterwards until a start is accepted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Strobe from the main decoder |
| main_opcode | input | 8 | First opcode byte that goes with the strobe |
| pc | input | 16 | Address of the prefix byte |
| hl | input | 16 | HL pair, the address of the memory operand |
| gpr_flat | input | 56 | Seven 8-bit registers B, C, D, E, H, L, A, with B lowest |
| flags_in | input | 8 | Current flag register |
| mem_rdata | input | 8 | Read data, valid the cycle after a request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| flags_we | output | 1 | Flag register write strobe |
| flags_out | output | 8 | New flag byte, valid with `flags_we` |
| done | output | 1 | Instruction complete |
| instr_len | output | 2 | Instruction length in bytes, valid with `done` |
| illegal | output | 1 | Unrecognised second byte |

## Verification
The bound checker watches several properties on every cycle. It checks the fetch address and its wrap after each accepted start, and that `done` lasts one cycle. It checks that every flag write clears N, sets H and keeps the low bits, that the error pulse excludes completion and memory traffic, and that an idle unit drives nothing. Other behaviour only shows up in the bench's directed scenarios, because it depends on the data fetched and on counting cycles. This covers the zero flag for each operand and bit index, and the three- versus four-cycle latency of register and memory operands. It also covers the read at HL, the decoding of bytes outside the range, and starts that are ignored because the opcode is wrong or the unit is busy.

// File: rtl/pfx_bit_pkg.sv
package pfx_bit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LATCH = 3'd2,
    ST_EXEC  = 3'd3,
    ST_MEMRD = 3'd4
  } pbu_state_e;

  // flag byte bit positions
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;

  // operand selector value that means memory at HL
  localparam logic [2:0] SEL_MEM = 3'd6;

  // selector -> slot in the packed register vector (slot 6 holds A)
  function automatic logic [2:0] gpr_slot(input logic [2:0] sel);
    return (sel == 3'd7) ? 3'd6 : sel;
  endfunction

endpackage

// File: rtl/pfx_bit_decode.sv
module pfx_bit_decode #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_q,
  output logic [2:0]        bit_idx,
  output logic [2:0]        opnd_sel,
  output logic              is_legal,
  output logic              is_mem
);
  import pfx_bit_pkg::*;

  // class field in the top two bits: 2'b01 marks the bit-test group
  localparam logic [1:0] CLASS_BIT = 2'b01;

  always_comb begin
    bit_idx  = op_q[5:3];
    opnd_sel = op_q[2:0];
    is_legal = (op_q[DATA_W-1 -: 2] == CLASS_BIT);
    is_mem   = (op_q[2:0] == SEL_MEM);
  end

endmodule

// File: rtl/pfx_bit_eval.sv
module pfx_bit_eval #(
  parameter int DATA_W  = 8,
  parameter int NUM_GPR = 7
) (
  input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
  input  logic [DATA_W-1:0]         mem_rdata,
  input  logic [2:0]                opnd_sel,
  input  logic [2:0]                bit_idx,
  input  logic                      use_mem,
  input  logic [DATA_W-1:0]         flags_in,
  output logic [DATA_W-1:0]         flags_res
);
  import pfx_bit_pkg::*;

  logic [DATA_W-1:0] gpr_arr [NUM_GPR];
  logic [DATA_W-1:0] operand;
  logic              bit_val;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
    assign gpr_arr[g] = gpr_flat[g*DATA_W +: DATA_W];
  end

  always_comb begin
    if (use_mem) operand = mem_rdata;
    else         operand = gpr_arr[gpr_slot(opnd_sel)];
    bit_val = operand[bit_idx];
  end

  always_comb begin
    flags_res         = flags_in;
    flags_res[FLAG_Z] = ~bit_val;
    flags_res[FLAG_N] = 1'b0;
    flags_res[FLAG_H] = 1'b1;
  end

endmodule

// File: rtl/pfx_bit_ctrl.sv
module pfx_bit_ctrl (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_ok,
  input  logic                    op_legal,
  input  logic                    op_is_mem,
  output pfx_bit_pkg::pbu_state_e state,
  output logic                    cap_op,
  output logic                    clr_op,
  output logic                    fetch_rd,
  output logic                    hl_rd,
  output logic                    finish,
  output logic                    bad_op
);
  import pfx_bit_pkg::*;

  pbu_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cap_op   = 1'b0;
    fetch_rd = 1'b0;
    hl_rd    = 1'b0;
    finish   = 1'b0;
    bad_op   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        fetch_rd = 1'b1;
        state_d  = ST_LATCH;
      end
      ST_LATCH: begin
        cap_op  = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (!op_legal) begin
          bad_op  = 1'b1;
          state_d = ST_IDLE;
        end else if (op_is_mem) begin
          hl_rd   = 1'b1;
          state_d = ST_MEMRD;
        end else begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_MEMRD: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    clr_op = finish | bad_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pfx_bit_unit.sv
module pfx_bit_unit #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          NUM_GPR     = 7,
  parameter int          LEN_W       = 2,
  parameter int          INSTR_LEN   = 2,
  parameter logic [7:0]  PREFIX_CODE = 8'hCB
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [DATA_W-1:0]         main_opcode,
  input  logic [ADDR_W-1:0]         pc,
  input  logic [ADDR_W-1:0]         hl,
  input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
  input  logic [DATA_W-1:0]         flags_in,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      mem_rd,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      flags_we,
  output logic [DATA_W-1:0]         flags_out,
  output logic                      done,
  output logic [LEN_W-1:0]          instr_len,
  output logic                      illegal
);
  import pfx_bit_pkg::*;

  localparam int SYNC_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  pbu_state_e        state;
  logic              cap_op, clr_op, fetch_rd, hl_rd, finish, bad_op;
  logic              start_ok, idle_w;
  logic [DATA_W-1:0] op_q, op_d;
  logic              op_en;
  logic [ADDR_W-1:0] pc_q, pc_d, fetch_addr;
  logic              pc_en;
  logic [2:0]        bit_idx, opnd_sel;
  logic              op_legal, op_is_mem;
  logic [DATA_W-1:0] flags_res;

  assign idle_w   = (state == ST_IDLE);
  assign start_ok = start && (main_opcode == PREFIX_CODE) && idle_w;

  // second opcode byte latch: loaded from read data, cleared at completion
  always_comb begin
    op_en = cap_op | clr_op;
    op_d  = cap_op ? mem_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  op_q <= '0;
    else if (op_en)  op_q <= op_d;
  end

  // program counter captured when the start is accepted
  always_comb begin
    pc_en = start_ok;
    pc_d  = pc;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  assign fetch_addr = pc_q + ADDR_W'(1);

  pfx_bit_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_ok (start_ok),
    .op_legal (op_legal),
    .op_is_mem(op_is_mem),
    .state    (state),
    .cap_op   (cap_op),
    .clr_op   (clr_op),
    .fetch_rd (fetch_rd),
    .hl_rd    (hl_rd),
    .finish   (finish),
    .bad_op   (bad_op)
  );

  pfx_bit_decode #(.DATA_W(DATA_W)) u_dec (
    .op_q    (op_q),
    .bit_idx (bit_idx),
    .opnd_sel(opnd_sel),
    .is_legal(op_legal),
    .is_mem  (op_is_mem)
  );

  pfx_bit_eval #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_eval (
    .gpr_flat (gpr_flat),
    .mem_rdata(mem_rdata),
    .opnd_sel (opnd_sel),
    .bit_idx  (bit_idx),
    .use_mem  (op_is_mem),
    .flags_in (flags_in),
    .flags_res(flags_res)
  );

  always_comb begin
    mem_rd    = fetch_rd | hl_rd;
    mem_addr  = fetch_rd ? fetch_addr : (hl_rd ? hl : '0);
    flags_we  = finish;
    flags_out = finish ? flags_res : '0;
    done      = finish;
    instr_len = finish ? LEN_W'(INSTR_LEN) : '0;
    illegal   = bad_op;
  end

endmodule

// File: rtl/pfx_bit_unit_chk.sv
module pfx_bit_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  main_opcode,
  input logic [15:0] pc,
  input logic [7:0]  flags_in,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        flags_we,
  input logic [7:0]  flags_out,
  input logic        done,
  input logic [1:0]  instr_len,
  input logic        illegal,
  input logic        idle
);
  logic [15:0] pc_inc;
  assign pc_inc = pc + 16'd1;

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && main_opcode == 8'hCB && idle) |=> (mem_rd && mem_addr == $past(pc_inc)));

  // R1
  wrong_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && main_opcode != 8'hCB && idle) |=> !mem_rd);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || flags_we) |-> (done && flags_we && instr_len == 2'd2));

  // R5
  flag_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (!flags_out[6] && flags_out[5] && flags_out[4:0] == flags_in[4:0]));

  // R9
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !flags_we && !mem_rd));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mem_rd && !done && !flags_we && !illegal));

endmodule

bind pfx_bit_unit pfx_bit_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .main_opcode(main_opcode),
  .pc         (pc),
  .flags_in   (flags_in),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .flags_we   (flags_we),
  .flags_out  (flags_out),
  .done       (done),
  .instr_len  (instr_len),
  .illegal    (illegal),
  .idle       (idle_w)
);

// File: tb/pfx_bit_unit_tb.sv
module pfx_bit_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  main_opcode = 8'h00;
  logic [15:0] pc = 16'h0100;
  logic [15:0] hl = 16'h8000;
  logic [55:0] gpr_flat;
  logic [7:0]  flags_in = 8'h00;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic        flags_we;
  logic [7:0]  flags_out;
  logic        done;
  logic [1:0]  instr_len;
  logic        illegal;

  logic [7:0]  gregs [7];
  logic [7:0]  resp_op = 8'h00;
  logic [7:0]  resp_mem = 8'h00;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) gpr_flat[i*8 +: 8] = gregs[i];
  end

  // memory responder: data one cycle after the request
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= (mem_addr == hl) ? resp_mem : resp_op;
  end

  pfx_bit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .main_opcode(main_opcode),
    .pc(pc), .hl(hl), .gpr_flat(gpr_flat), .flags_in(flags_in),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .flags_we(flags_we), .flags_out(flags_out), .done(done),
    .instr_len(instr_len), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one instruction; results indexed by cycle after the start edge
  task automatic run_op(input logic [7:0] op2, input logic [7:0] mb, input logic [7:0] pfx,
                        output int dcyc, output int icyc, output int dcnt,
                        output logic [7:0] fl, output logic [1:0] len,
                        output logic rd1, output logic [15:0] a1,
                        output logic rd3, output logic [15:0] a3, output int rdcnt);
    resp_op = op2; resp_mem = mb;
    dcyc = 0; icyc = 0; dcnt = 0; fl = 0; len = 0; rdcnt = 0;
    rd1 = 0; a1 = 0; rd3 = 0; a3 = 0;
    @(negedge clk); start = 1'b1; main_opcode = pfx;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) begin start = 1'b0; main_opcode = 8'h00; end
      if (done) begin dcnt++; if (dcyc == 0) begin dcyc = i; fl = flags_out; len = instr_len; end end
      if (illegal && icyc == 0) icyc = i;
      if (mem_rd) rdcnt++;
      if (i == 1) begin rd1 = mem_rd; a1 = mem_addr; end
      if (i == 3) begin rd3 = mem_rd; a3 = mem_addr; end
    end
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] opnd, input logic [2:0] b, input logic [7:0] fin);
    return {~opnd[b], 1'b0, 1'b1, fin[4:0]};
  endfunction

  task automatic t_reset();
    chk(!mem_rd && !done && !flags_we && !illegal && instr_len == 0 && flags_out == 0,
        "R11 outputs low after reset", {mem_rd, done, flags_we, illegal}, 0);
  endtask

  task automatic t_reg(input logic [2:0] b, input logic [2:0] sel, input logic [7:0] fin);
    int dc, ic, dn, rc; logic [7:0] fl; logic [1:0] ln; logic r1, r3; logic [15:0] a1, a3;
    logic [7:0] opnd;
    flags_in = fin;
    opnd = gregs[(sel == 3'd7) ? 6 : sel];
    run_op({2'b01, b, sel}, 8'h00, 8'hCB, dc, ic, dn, fl, ln, r1, a1, r3, a3, rc);
    chk(r1 && a1 == pc + 16'd1, "R2 fetch at pc+1", a1, pc + 16'd1);
    chk(dc == 3 && dn == 1, "R6 register done in cycle 3", dc, 3);
    chk(!r3, "R6 no memory read on register operand", r3, 0);
    chk(fl == exp_flags(opnd, b, fin), "R3 R4 R5 flag result", fl, exp_flags(opnd, b, fin));
    chk(ln == 2'd2, "R8 length 2", ln, 2);
    chk(ic == 0, "R9 no illegal on valid op", ic, 0);
  endtask

  task automatic t_mem(input logic [2:0] b, input logic [7:0] mb, input logic [7:0] fin);
    int dc, ic, dn, rc; logic [7:0] fl; logic [1:0] ln; logic r1, r3; logic [15:0] a1, a3;
    flags_in = fin;
    run_op({2'b01, b, 3'd6}, mb, 8'hCB, dc, ic, dn, fl, ln, r1, a1, r3, a3, rc);
    chk(r3 && a3 == hl, "R7 read at HL in cycle 3", a3, hl);
    chk(dc == 4 && dn == 1, "R7 memory done in cycle 4", dc, 4);
    chk(fl == exp_flags(mb, b, fin), "R7 R4 flag from memory byte", fl, exp_flags(mb, b, fin));
    chk(ln == 2'd2, "R8 length 2 memory", ln, 2);
  endtask

  task automatic t_illegal(input logic [7:0] op2);
    int dc, ic, dn, rc; logic [7:0] fl; logic [1:0] ln; logic r1, r3; logic [15:0] a1, a3;
    run_op(op2, 8'h00, 8'hCB, dc, ic, dn, fl, ln, r1, a1, r3, a3, rc);
    chk(ic == 3, "R9 illegal pulse in cycle 3", ic, 3);
    chk(dn == 0 && rc == 1, "R9 no done and only the fetch read", {dn[15:0], rc[15:0]}, 32'h0000_0001);
  endtask

  task automatic t_wrong_prefix();
    int dc, ic, dn, rc; logic [7:0] fl; logic [1:0] ln; logic r1, r3; logic [15:0] a1, a3;
    run_op(8'h47, 8'h00, 8'hCA, dc, ic, dn, fl, ln, r1, a1, r3, a3, rc);
    chk(rc == 0 && dn == 0 && ic == 0, "R1 non-prefix start ignored", rc, 0);
  endtask

  task automatic t_busy();
    int dn = 0, rc = 0, dcyc = 0;
    resp_op = 8'h7F; flags_in = 8'h00;
    @(negedge clk); start = 1'b1; main_opcode = 8'hCB;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 3) begin start = 1'b0; main_opcode = 8'h00; end
      if (done) begin dn++; if (dcyc == 0) dcyc = i; end
      if (mem_rd) rc++;
    end
    chk(dn == 1 && dcyc == 3, "R10 start while busy gives one completion", dn, 1);
    chk(rc == 1, "R10 start while busy gives no extra fetch", rc, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    gregs[0] = 8'h01; gregs[1] = 8'hFE; gregs[2] = 8'h80; gregs[3] = 8'h7F;
    gregs[4] = 8'hA5; gregs[5] = 8'h5A; gregs[6] = 8'h10;
    repeat (3) @(negedge clk);
    t_reset();            // R11 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();            // R11 after release
    t_reg(3'd0, 3'd0, 8'h1F);   // B bit0 = 1
    t_reg(3'd0, 3'd1, 8'hC0);   // C bit0 = 0
    t_reg(3'd7, 3'd2, 8'h00);   // D bit7 = 1
    t_reg(3'd7, 3'd3, 8'h15);   // E bit7 = 0
    t_reg(3'd2, 3'd4, 8'hFF);   // H bit2 = 1
    t_reg(3'd1, 3'd5, 8'h0A);   // L bit1 = 1
    t_reg(3'd4, 3'd7, 8'h10);   // A bit4 = 1
    t_reg(3'd5, 3'd7, 8'hE3);   // A bit5 = 0
    t_mem(3'd6, 8'h40, 8'h1B);
    t_mem(3'd3, 8'hF7, 8'h00);
    t_illegal(8'h00);
    t_illegal(8'h3F);
    t_illegal(8'h80);
    t_illegal(8'hC7);
    t_reg(3'd1, 3'd0, 8'h00);   // recovery after illegal
    t_wrong_prefix();
    t_busy();
    pc = 16'hFFFF;
    t_reg(3'd0, 3'd0, 8'h00);   // R2 wrap to 0x0000
    pc = 16'h0100;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule